// File: doc/BRIEF.md
# Quadrant-Interleaved DRAM Command Scheduler

This block decides when row-activate and column-access commands may be sent to a DRAM core whose banks sit in four quadrants. Requests arrive one at a time, each tagged with a bank number. The low two bits of the bank number give the quadrant. Each quadrant has a single holding slot. A request stays in its slot until that quadrant's own timers allow it to go. Spacing limits apply only within a quadrant, so traffic to different quadrants can interleave on consecutive clocks. One clock equals one bit time on the data links.

Each slot is a small state machine with three states. `SLOT_EMPTY` moves to `SLOT_ROW` or to `SLOT_COL` when a request is accepted, depending on the request's kind. Either occupied state returns to `SLOT_EMPTY` when the slot is granted, whether the command issues or is rejected.

A round-robin arbiter picks one eligible slot per clock. A minimal bank model records which banks have been activated since reset. A column request to a bank that was never activated is dropped, and an error strobe is raised instead of a command. For every issued column command, the scheduler names the half of the 16-link data bus that carries the data. A per-half start pulse then marks the beginning of that access's 8-bit-time data window. The window lies in the first or second half of a free-running 16-bit-time frame.

Top module: `quad_cmd_sched`

## Requirements
- R1: A row command to a quadrant is never issued earlier than T_RR (default 32) clocks after the previous row command to the same quadrant. If the request is waiting, it issues in exactly that clock when it wins arbitration.
- R2: A row or column timer running in one quadrant never delays a command to any other quadrant.
- R3: A column command to a quadrant is never issued earlier than T_CC (default 16) clocks after the previous issued column command to the same quadrant.
- R4: The quadrant is req_bank[1:0]. cmd_half equals the quadrant's bit 0: value 0 selects links 0 to 7, and value 1 selects links 8 to 15.
- R5: A frame phase counts 0 in the first clock after reset and wraps modulo T_CC. For each issued column command, data_start[cmd_half] pulses exactly once. The pulse comes in the first later clock whose phase equals the quadrant's slot start. That start is phase 0 for quadrants 0 and 1, and phase T_CC/2 for quadrants 2 and 3.
- R6: At most one command is granted per clock. Eligible slots are searched in rising quadrant order, starting just after the last granted quadrant. Quadrant 0 is searched first after reset.
- R7: A granted column request to a bank with no row command since reset raises cmd_err for one clock. In that clock cmd_valid stays low, the slot empties, and the quadrant's column timer and data window are untouched.
- R8: req_ready is high exactly when the slot of req_bank's quadrant is empty. An accepted request is eligible from the next clock. Its kind (req_col 0 = row, 1 = column) is reported on cmd_col.
- R9: During reset cmd_valid, cmd_err and data_start are low, req_ready is high, and every bank counts as not activated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_col | input | 1 | Request kind: 0 row activate, 1 column access |
| req_bank | input | $clog2(NUM_BANKS) | Target bank; bits [1:0] give the quadrant |
| req_ready | output | 1 | Slot for the request's quadrant is free |
| cmd_valid | output | 1 | A command is issued this clock |
| cmd_col | output | 1 | Kind of the issued command |
| cmd_bank | output | $clog2(NUM_BANKS) | Bank of the issued command |
| cmd_half | output | 1 | Data-link half used by a column command |
| cmd_err | output | 1 | Column request rejected: bank not activated |
| data_start | output | 2 | Per-half pulse at the start of a data window |

## Verification
The bench drives the spacing limits hardest. It sends a second row to a quadrant 32 clocks after the first, and a second column 16 clocks after the first. A counter that reloaded one short, or that was shared across quadrants, would issue a clock early or would stall a neighbouring quadrant. A column is also sent to a bank that was never activated, both at start-up and later. A scheduler that ignored the bank model would issue it. A scheduler that started the column timer on rejection would delay the next legal column. Long random traffic checks the round-robin order and the data-window pulses. These catch a fixed-priority arbiter, and a window that starts in the issue clock or in the wrong half of the frame.

// File: rtl/qsched_pkg.sv
package qsched_pkg;
    localparam int NQ = 4;
    localparam int QW = 2;

    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_ROW   = 2'd1,
        SLOT_COL   = 2'd2
    } slot_state_e;
endpackage

// File: rtl/qsched_slot.sv
module qsched_slot
    import qsched_pkg::*;
#(
    parameter int QIDX   = 0,
    parameter int BANK_W = 3,
    parameter int T_RR   = 32,
    parameter int T_CC   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(T_CC)-1:0]   phase,
    input  logic                      enq,
    input  logic                      enq_col,
    input  logic [BANK_W-1:0]         enq_bank,
    input  logic                      grant,
    input  logic                      bank_open,
    output logic                      busy,
    output logic                      elig,
    output logic                      is_col,
    output logic [BANK_W-1:0]         bank,
    output logic                      data_go
);
    localparam int RR_W = $clog2(T_RR);
    localparam int CC_W = $clog2(T_CC);
    localparam logic [CC_W-1:0] SLOT_START = CC_W'((QIDX / 2) * (T_CC / 2));

    slot_state_e     state_q, state_d;
    logic [RR_W-1:0] rr_cnt;
    logic [CC_W-1:0] cc_cnt;
    logic            pend;
    logic            col_go;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (enq) state_d = enq_col ? SLOT_COL : SLOT_ROW;
            SLOT_ROW,
            SLOT_COL:   if (grant) state_d = SLOT_EMPTY;
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        busy    = (state_q != SLOT_EMPTY);
        is_col  = (state_q == SLOT_COL);
        elig    = ((state_q == SLOT_ROW) && (rr_cnt == '0)) ||
                  ((state_q == SLOT_COL) && (cc_cnt == '0));
        col_go  = grant && (state_q == SLOT_COL) && bank_open;
        data_go = pend && (phase == SLOT_START);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank   <= '0;
            rr_cnt <= '0;
            cc_cnt <= '0;
            pend   <= 1'b0;
        end else begin
            if (enq) bank <= enq_bank;
            if (grant && (state_q == SLOT_ROW)) rr_cnt <= RR_W'(T_RR - 1);
            else if (rr_cnt != '0)              rr_cnt <= rr_cnt - 1'b1;
            if (col_go)             cc_cnt <= CC_W'(T_CC - 1);
            else if (cc_cnt != '0)  cc_cnt <= cc_cnt - 1'b1;
            if (col_go)       pend <= 1'b1;
            else if (data_go) pend <= 1'b0;
        end
    end

    // R1
    row_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && state_q == SLOT_ROW) |-> (rr_cnt == '0));

    // R3
    col_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && state_q == SLOT_COL) |-> (cc_cnt == '0));

    // R5
    data_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_go |=> !data_go);
endmodule

// File: rtl/qsched_arb.sv
module qsched_arb
    import qsched_pkg::*;
#(
    parameter int N = NQ
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    output logic [N-1:0]         grant,
    output logic [$clog2(N)-1:0] gidx,
    output logic                 gany
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] ptr;

    always_comb begin
        grant = '0;
        gidx  = '0;
        gany  = 1'b0;
        for (int k = 1; k <= N; k++) begin
            logic [IW-1:0] idx;
            idx = IW'((int'(ptr) + k) % N);
            if (!gany && req[idx]) begin
                gany       = 1'b1;
                gidx       = idx;
                grant[idx] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ptr <= IW'(N - 1);
        else if (gany) ptr <= gidx;
    end

    // R6
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R6
    grant_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);
endmodule

// File: rtl/quad_cmd_sched.sv
module quad_cmd_sched
    import qsched_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int T_RR      = 32,
    parameter int T_CC      = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_col,
    input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
    output logic                         req_ready,
    output logic                         cmd_valid,
    output logic                         cmd_col,
    output logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
    output logic                         cmd_half,
    output logic                         cmd_err,
    output logic [1:0]                   data_start
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int PH_W   = $clog2(T_CC);

    logic [PH_W-1:0]      phase;
    logic [NUM_BANKS-1:0] opened;
    logic [QW-1:0]        req_quad;
    logic [NQ-1:0]        slot_busy, slot_elig, slot_col, slot_open, slot_go, grant;
    logic [BANK_W-1:0]    slot_bank [NQ];
    logic [QW-1:0]        gidx;
    logic                 gany, g_col, reject;
    logic [BANK_W-1:0]    g_bank;

    assign req_quad  = req_bank[QW-1:0];
    assign req_ready = !slot_busy[req_quad];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       phase <= '0;
        else if (phase == PH_W'(T_CC - 1)) phase <= '0;
        else                              phase <= phase + 1'b1;
    end

    for (genvar q = 0; q < NQ; q++) begin : g_slot
        assign slot_open[q] = opened[slot_bank[q]];
        qsched_slot #(
            .QIDX(q), .BANK_W(BANK_W), .T_RR(T_RR), .T_CC(T_CC)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .phase    (phase),
            .enq      (req_valid && req_ready && (req_quad == QW'(q))),
            .enq_col  (req_col),
            .enq_bank (req_bank),
            .grant    (grant[q]),
            .bank_open(slot_open[q]),
            .busy     (slot_busy[q]),
            .elig     (slot_elig[q]),
            .is_col   (slot_col[q]),
            .bank     (slot_bank[q]),
            .data_go  (slot_go[q])
        );
    end

    qsched_arb #(.N(NQ)) u_arb (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (slot_elig),
        .grant(grant),
        .gidx (gidx),
        .gany (gany)
    );

    assign g_bank = slot_bank[gidx];
    assign g_col  = slot_col[gidx];
    assign reject = g_col && !opened[g_bank];

    always_comb begin
        cmd_valid  = gany && !reject;
        cmd_err    = gany && reject;
        cmd_col    = g_col;
        cmd_bank   = g_bank;
        cmd_half   = gidx[0];
        data_start = {slot_go[1] | slot_go[3], slot_go[0] | slot_go[2]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               opened <= '0;
        else if (gany && !g_col)  opened[g_bank] <= 1'b1;
    end
endmodule

// File: tb/quad_cmd_sched_tb.sv
module quad_cmd_sched_tb;
    localparam int NB   = 8;
    localparam int TRR  = 32;
    localparam int TCC  = 16;
    localparam int HALF = TCC / 2;
    localparam int SN   = 14;
    localparam int RUN  = 4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       req_valid = 1'b0, req_col = 1'b0;
    logic [2:0] req_bank = '0;
    logic       req_ready, cmd_valid, cmd_col, cmd_half, cmd_err;
    logic [2:0] cmd_bank;
    logic [1:0] data_start;

    quad_cmd_sched #(.NUM_BANKS(NB), .T_RR(TRR), .T_CC(TCC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_col(req_col),
        .req_bank(req_bank), .req_ready(req_ready), .cmd_valid(cmd_valid),
        .cmd_col(cmd_col), .cmd_bank(cmd_bank), .cmd_half(cmd_half),
        .cmd_err(cmd_err), .data_start(data_start)
    );

    int n_tests = 0, n_fail = 0, cyc = 0;
    bit m_valid[4], m_col[4], m_pend[4], m_open[NB];
    int m_bank[4], m_rr[4], m_cc[4], last_row[4], last_col[4];
    int m_ptr, m_phase;
    bit s_col[SN];
    int s_bank[SN];
    int s_head = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
        end
    endtask

    initial begin
        // R7 closed bank first, then activations and column traffic
        s_col = '{1,0,0,0,0,0,1,1,1,1,1,1,1,0};
        s_bank = '{0,0,4,1,2,3,0,4,1,5,2,3,0,4};
        for (int q = 0; q < 4; q++) begin
            m_valid[q] = 0; m_col[q] = 0; m_pend[q] = 0; m_bank[q] = 0;
            m_rr[q] = 0; m_cc[q] = 0; last_row[q] = -100000; last_col[q] = -100000;
        end
        for (int b = 0; b < NB; b++) m_open[b] = 0;
        m_ptr = 3; m_phase = 0;

        repeat (3) @(negedge clk);
        #1;
        check(cmd_valid == 0, "R9 cmd_valid in reset", int'(cmd_valid), 0);
        check(cmd_err == 0, "R9 cmd_err in reset", int'(cmd_err), 0);
        check(data_start == 0, "R9 data_start in reset", int'(data_start), 0);
        check(req_ready == 1, "R9 req_ready in reset", int'(req_ready), 1);
        @(negedge clk);
        rst_n = 1'b1;

        for (cyc = 0; cyc < RUN; cyc++) begin
            int g, rq;
            bit e_rej, e_valid, e_err, e_ready, acc;
            bit [1:0] e_ds;
            if (s_head < SN) begin
                req_valid = 1; req_col = s_col[s_head]; req_bank = 3'(s_bank[s_head]);
            end else if (cyc < 300) begin
                req_valid = 0;
            end else begin
                req_valid = ($urandom_range(0, 2) != 0);
                req_col   = ($urandom_range(0, 4) < 3);
                req_bank  = 3'($urandom_range(0, NB - 1));
            end
            #1;
            g = -1;
            for (int k = 1; k <= 4; k++) begin
                int q;
                q = (m_ptr + k) % 4;
                if (g < 0 && m_valid[q] && (m_col[q] ? m_cc[q] == 0 : m_rr[q] == 0)) g = q;
            end
            e_rej   = (g >= 0) && m_col[g] && !m_open[m_bank[g]];
            e_valid = (g >= 0) && !e_rej;
            e_err   = (g >= 0) && e_rej;
            e_ds    = 2'b00;
            for (int q = 0; q < 4; q++)
                if (m_pend[q] && m_phase == (q / 2) * HALF) e_ds[q % 2] = 1'b1;
            rq      = int'(req_bank) % 4;
            e_ready = !m_valid[rq];

            check(cmd_valid == e_valid, "R1 R2 R3 R6 cmd_valid", int'(cmd_valid), int'(e_valid));
            if (e_valid && cmd_valid) begin
                check(int'(cmd_bank) == m_bank[g], "R6 cmd_bank", int'(cmd_bank), m_bank[g]);
                check(cmd_col == m_col[g], "R8 cmd_col", int'(cmd_col), int'(m_col[g]));
                check(int'(cmd_half) == g % 2, "R4 cmd_half", int'(cmd_half), g % 2);
            end
            check(cmd_err == e_err, "R7 cmd_err", int'(cmd_err), int'(e_err));
            check(data_start == e_ds, "R5 data_start", int'(data_start), int'(e_ds));
            check(req_ready == e_ready, "R8 req_ready", int'(req_ready), int'(e_ready));

            if (cmd_valid) begin
                int dq;
                dq = int'(cmd_bank) % 4;
                if (!cmd_col) begin
                    check(cyc - last_row[dq] >= TRR, "R1 row spacing", cyc - last_row[dq], TRR);
                    last_row[dq] = cyc;
                end else begin
                    check(cyc - last_col[dq] >= TCC, "R3 col spacing", cyc - last_col[dq], TCC);
                    last_col[dq] = cyc;
                end
            end

            // advance reference model to the next clock
            acc = req_valid && e_ready;
            for (int q = 0; q < 4; q++) begin
                if (m_pend[q] && m_phase == (q / 2) * HALF) m_pend[q] = 0;
                if (m_rr[q] > 0) m_rr[q]--;
                if (m_cc[q] > 0) m_cc[q]--;
            end
            if (g >= 0) begin
                m_valid[g] = 0;
                m_ptr = g;
                if (!m_col[g]) begin
                    m_open[m_bank[g]] = 1;
                    m_rr[g] = TRR - 1;
                end else if (!e_rej) begin
                    m_cc[g] = TCC - 1;
                    m_pend[g] = 1;
                end
            end
            if (acc) begin
                m_valid[rq] = 1; m_col[rq] = req_col; m_bank[rq] = int'(req_bank);
                if (s_head < SN) s_head++;
            end
            m_phase = (m_phase + 1) % TCC;
            @(negedge clk);
        end
        check(s_head == SN, "R8 directed script accepted", s_head, SN);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R6 run did not complete actual=%0d expected=%0d", cyc, RUN);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule